// File: doc/BRIEF.md
# UART receiver with line status

This block turns an asynchronous serial line into parallel characters. It uses a clock-enable pulse from an external baud divider, which fires sixteen times per bit period. The line goes through a two-flop synchronizer. The control then looks for a high-to-low step and checks the candidate start bit half a bit later, so that a short low glitch is thrown away. After a valid start it takes the data bits, an optional parity bit and the stop bit, each at the centre of its bit cell.

The finished character goes into a holding register, and the line-status flags are updated in the same clock cycle. A host reads the character through the read strobe for the holding register and reads the error flags through a separate status-read strobe. Character length and parity are set by static line-control inputs, which must not change while a character is being received.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `rxData` is 0 and `dataReady`, `overrunErr`, `parityErr` and `frameErr` are all 0.
- R2: The line is sampled on each `tickEn` pulse. A start is a sample of 0 that follows a sample of 1. The start is accepted only if the line is still 0 on the 8th tick after it. Otherwise no character is produced and the block waits for a new falling edge.
- R3: Data bits are sampled every 16 ticks after the start centre and are taken LSB first. The number of data bits is set by `lenSel`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of `rxData` read 0.
- R4: When `parityOn` is 1, one parity bit follows the data. With `parityEven` = 1, the data bits plus the parity bit hold an even number of ones. With `parityEven` = 0, they hold an odd number.
- R5: `dataReady` becomes 1 in the cycle after a character is loaded, and `rxData` then holds that character. A one-cycle `holdRead` pulse clears `dataReady`, unless a new load happens in the same cycle.
- R6: If a character is loaded while `dataReady` is 1 and `holdRead` is not active in that cycle, `overrunErr` becomes 1 and `rxData` takes the new character.
- R7: `parityErr` becomes 1 when a character loaded with `parityOn` = 1 breaks the parity rule of R4.
- R8: `frameErr` becomes 1 when the stop-bit sample is 0.
- R9: `overrunErr`, `parityErr` and `frameErr` stay set through later clean characters until a `statusRead` pulse clears them. If a load sets a flag in the same cycle as `statusRead`, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | 16x oversampling enable from the baud divider |
| serialIn | input | 1 | Asynchronous serial input, idle high |
| lenSel | input | 2 | Data-bit count select (5 to 8) |
| parityOn | input | 1 | A parity bit is expected |
| parityEven | input | 1 | 1 selects even parity, 0 selects odd parity |
| holdRead | input | 1 | Host read strobe for the holding register |
| statusRead | input | 1 | Host read strobe for the status flags, clears the error flags |
| rxData | output | 8 | Holding register, right-aligned and zero-filled |
| dataReady | output | 1 | A character is waiting in the holding register |
| overrunErr | output | 1 | A character was replaced before it was read |
| parityErr | output | 1 | Sticky parity mismatch |
| frameErr | output | 1 | Sticky stop-bit error |

## Verification
A wrong tick count or bit index inside the control shows up at the ports within one character. Either `dataReady` rises in the wrong clock cycle, or `rxData` holds shifted or misaligned bits, so the cycle-by-cycle comparison catches it at the load edge of the first affected character. A corrupted parity accumulator or a lost sticky flag is seen when the next load, or the next clean character, leaves the flags different from the behavioural model. A start check that misses a noise pulse shows up as a spurious `dataReady` about one character time after the glitch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int MAX_BITS = 8;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic bitVal;   // synchronized line value at this sample
    logic accept;   // start bit confirmed
    logic shift;    // data bit sample
    logic takePar;  // parity bit sample
    logic load;     // stop bit sample: move character to the holding register
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      serialIn,
  input  logic [1:0] lenSel,
  input  logic      parityOn,
  output rxStrobe_t strb
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  logic          sync1, sync2, prevSample;
  rxState_t      state;
  logic [CW-1:0] tickCnt;
  logic [2:0]    bitCnt;
  logic [2:0]    lastBit;
  logic          atFull;

  assign lastBit = 3'(lenSel) + 3'(MIN_BITS - 1);
  assign atFull  = tickEn && (tickCnt == FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1      <= 1'b1;
      sync2      <= 1'b1;
      prevSample <= 1'b1;
      state      <= ST_IDLE;
      tickCnt    <= '0;
      bitCnt     <= '0;
    end else begin
      sync1 <= serialIn;
      sync2 <= sync1;
      if (tickEn) begin
        prevSample <= sync2;
        case (state)
          ST_IDLE: begin
            if (prevSample && !sync2) begin
              state   <= ST_START;
              tickCnt <= '0;
            end
          end
          ST_START: begin
            if (tickCnt == HALF) begin
              tickCnt <= '0;
              bitCnt  <= '0;
              state   <= sync2 ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (tickCnt == FULL) begin
              tickCnt <= '0;
              if (bitCnt == lastBit) state <= parityOn ? ST_PARITY : ST_STOP;
              else                   bitCnt <= bitCnt + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_PARITY: begin
            if (tickCnt == FULL) begin
              tickCnt <= '0;
              state   <= ST_STOP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (tickCnt == FULL) begin
              tickCnt <= '0;
              state   <= ST_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.bitVal  = sync2;
    strb.accept  = tickEn && (state == ST_START) && (tickCnt == HALF) && !sync2;
    strb.shift   = atFull && (state == ST_DATA);
    strb.takePar = atFull && (state == ST_PARITY);
    strb.load    = atFull && (state == ST_STOP);
  end

  // R3: at most one sampling strobe per cycle
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.accept, strb.shift, strb.takePar, strb.load}));

  // R2: the bit timer only moves on oversample ticks
  a_r2_timer_gated: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tickCnt));

  // R2: a confirmed start always leads into data sampling
  a_r2_accept_to_data: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (state == ST_DATA));

endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strb,
  input  logic [1:0]          lenSel,
  input  logic                parityOn,
  input  logic                parityEven,
  input  logic                holdRead,
  input  logic                statusRead,
  output logic [MAX_BITS-1:0] rxData,
  output logic                dataReady,
  output logic                overrunErr,
  output logic                parityErr,
  output logic                frameErr
);

  localparam int SW = $clog2(MAX_BITS + 1);

  logic [MAX_BITS-1:0] shiftReg;
  logic                parAcc, parBit;
  logic [SW-1:0]       nBits;
  logic [MAX_BITS-1:0] aligned;
  logic                parMismatch;

  assign nBits       = SW'(lenSel) + SW'(MIN_BITS);
  assign aligned     = shiftReg >> (SW'(MAX_BITS) - nBits);
  assign parMismatch = parityOn && (parityEven ? (parAcc ^ parBit) : !(parAcc ^ parBit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
    end else begin
      if (strb.accept) parAcc <= 1'b0;
      if (strb.shift) begin
        shiftReg <= {strb.bitVal, shiftReg[MAX_BITS-1:1]};
        parAcc   <= parAcc ^ strb.bitVal;
      end
      if (strb.takePar) parBit <= strb.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      dataReady  <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      if (strb.load) begin
        rxData    <= aligned;
        dataReady <= 1'b1;
      end else if (holdRead) begin
        dataReady <= 1'b0;
      end
      overrunErr <= (overrunErr && !statusRead) || (strb.load && dataReady && !holdRead);
      parityErr  <= (parityErr  && !statusRead) || (strb.load && parMismatch);
      frameErr   <= (frameErr   && !statusRead) || (strb.load && !strb.bitVal);
    end
  end

  a_r5_ready_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> dataReady);

  a_r6_overrun_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(dataReady) && $past(strb.load));

  a_r8_frame_only_on_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> $past(strb.load));

  a_r9_sticky_flags: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !statusRead) |=> parityErr);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       serialIn,
  input  logic [1:0] lenSel,
  input  logic       parityOn,
  input  logic       parityEven,
  input  logic       holdRead,
  input  logic       statusRead,
  output logic [7:0] rxData,
  output logic       dataReady,
  output logic       overrunErr,
  output logic       parityErr,
  output logic       frameErr
);

  rxStrobe_t strb;

  uart_rx_ctrl #(.OVS(OVS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .serialIn (serialIn),
    .lenSel   (lenSel),
    .parityOn (parityOn),
    .strb     (strb)
  );

  uart_rx_dpath dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lenSel     (lenSel),
    .parityOn   (parityOn),
    .parityEven (parityEven),
    .holdRead   (holdRead),
    .statusRead (statusRead),
    .rxData     (rxData),
    .dataReady  (dataReady),
    .overrunErr (overrunErr),
    .parityErr  (parityErr),
    .frameErr   (frameErr)
  );

endmodule

// File: tb/uart_rx_status_tb_top.sv
module uart_rx_status_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       serialIn = 1'b1;
  logic [1:0] lenSel = 2'b11;
  logic       parityOn = 1'b0;
  logic       parityEven = 1'b0;
  logic       holdRead = 1'b0;
  logic       statusRead = 1'b0;
  logic [7:0] rxData;
  logic       dataReady, overrunErr, parityErr, frameErr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int tickDiv = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_rx_status dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .serialIn(serialIn),
    .lenSel(lenSel), .parityOn(parityOn), .parityEven(parityEven),
    .holdRead(holdRead), .statusRead(statusRead), .rxData(rxData),
    .dataReady(dataReady), .overrunErr(overrunErr), .parityErr(parityErr),
    .frameErr(frameErr)
  );

  // tick every 4 clocks
  always @(negedge clk) begin
    tickEn  = (tickDiv == 3);
    tickDiv = (tickDiv + 1) % 4;
  end

  // ---------------- behavioural reference model ----------------
  int mS1 = 1, mS2 = 1, mPrev = 1;
  bit hunting = 1;
  int t = 0;
  int mVal = 0, mParAcc = 0, mParBit = 0;
  int mHold = 0;
  bit mDr = 0, mOv = 0, mPe = 0, mFe = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPrev = 1; hunting = 1; t = 0;
      mVal = 0; mParAcc = 0; mParBit = 0; mHold = 0;
      mDr = 0; mOv = 0; mPe = 0; mFe = 0;
    end else begin
      int line;
      bit loadNow;
      bit oldDr;
      line    = mS2;
      loadNow = 0;
      oldDr   = mDr;
      if (tickEn) begin
        if (hunting) begin
          if (mPrev == 1 && line == 0) begin
            hunting = 0;
            t = 0;
          end
        end else begin
          t++;
          if (t == 8) begin
            if (line != 0) hunting = 1;
            else begin
              mVal = 0;
              mParAcc = 0;
            end
          end else if (t > 8 && ((t - 8) % 16) == 0) begin
            int k, nb;
            k  = (t - 8) / 16;
            nb = 5 + int'(lenSel);
            if (k <= nb) begin
              if (line != 0) mVal = mVal | (1 << (k - 1));
              mParAcc = mParAcc ^ line;
            end else if (parityOn && k == nb + 1) begin
              mParBit = line;
            end else begin
              loadNow = 1;
              hunting = 1;
            end
          end
        end
        mPrev = line;
      end
      if (holdRead) mDr = 0;
      if (statusRead) begin
        mOv = 0; mPe = 0; mFe = 0;
      end
      if (loadNow) begin
        int sum;
        if (oldDr && !holdRead) mOv = 1;
        mDr   = 1;
        mHold = mVal;
        sum   = mParAcc ^ mParBit;
        if (parityOn && ((parityEven && sum == 1) || (!parityEven && sum == 0))) mPe = 1;
        if (line == 0) mFe = 1;
      end
      mS2 = mS1;
      mS1 = int'(serialIn);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(rxData == 8'(mHold), "R3 rxData vs model", rxData, mHold);
      check(dataReady == mDr, "R5 dataReady vs model", dataReady, mDr);
      check(overrunErr == mOv, "R6 overrunErr vs model", overrunErr, mOv);
      check(parityErr == mPe, "R7 parityErr vs model", parityErr, mPe);
      check(frameErr == mFe, "R8 frameErr vs model", frameErr, mFe);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic holdLine(input logic v, input int clocks);
    serialIn = v;
    waitClk(clocks);
  endtask

  task automatic sendChar(input logic [7:0] d, input bit flipPar, input logic stopVal);
    int nb;
    logic p;
    nb = 5 + int'(lenSel);
    p  = 1'b0;
    holdLine(1'b0, 64);
    for (int i = 0; i < nb; i++) begin
      holdLine(d[i], 64);
      p = p ^ d[i];
    end
    if (parityOn) holdLine((parityEven ? p : ~p) ^ flipPar, 64);
    holdLine(stopVal, 64);
    holdLine(1'b1, 96);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    waitClk(5);
    // R1: reset state
    check(rxData == 8'h00 && !dataReady && !overrunErr && !parityErr && !frameErr,
          "R1 reset outputs", {rxData, dataReady, overrunErr, parityErr, frameErr}, 0);
    rstN = 1'b1;
    waitClk(20);
    check(!dataReady, "R1 idle after reset", dataReady, 0);

    // R3/R5: 8 data bits, no parity
    lenSel = 2'b11; parityOn = 0;
    sendChar(8'hA5, 0, 1'b1);
    check(rxData == 8'hA5, "R3 8-bit LSB first", rxData, 8'hA5);
    check(dataReady, "R5 ready after load", dataReady, 1);
    pulse(holdRead);
    check(!dataReady, "R5 cleared by read", dataReady, 0);

    // R4/R3: 5 bits even parity, zero fill
    lenSel = 2'b00; parityOn = 1; parityEven = 1;
    sendChar(8'hF3, 0, 1'b1);
    check(rxData == 8'h13, "R3 5-bit zero fill", rxData, 8'h13);
    check(!parityErr, "R4 even parity ok", parityErr, 0);
    pulse(holdRead);

    // R4/R7: 7 bits odd parity, correct then wrong
    lenSel = 2'b10; parityEven = 0;
    sendChar(8'h55, 0, 1'b1);
    check(rxData == 8'h55 && !parityErr, "R4 odd parity ok", {parityErr, rxData}, 8'h55);
    pulse(holdRead);
    sendChar(8'h2C, 1, 1'b1);
    check(parityErr, "R7 parity mismatch", parityErr, 1);
    pulse(holdRead);

    // R9: sticky through a clean character, cleared by status read
    sendChar(8'h11, 0, 1'b1);
    check(parityErr, "R9 parity flag sticky", parityErr, 1);
    pulse(statusRead);
    check(!parityErr, "R9 cleared by status read", parityErr, 0);
    pulse(holdRead);

    // R6: overrun with 6-bit characters, no parity
    lenSel = 2'b01; parityOn = 0;
    sendChar(8'h0A, 0, 1'b1);
    check(!overrunErr, "R6 no overrun yet", overrunErr, 0);
    sendChar(8'h35, 0, 1'b1);
    check(overrunErr, "R6 overrun set", overrunErr, 1);
    check(rxData == 8'h35, "R6 newer char kept", rxData, 8'h35);
    pulse(holdRead);
    pulse(statusRead);
    check(!overrunErr, "R9 overrun cleared", overrunErr, 0);

    // R8: framing error
    lenSel = 2'b11;
    sendChar(8'h3C, 0, 1'b0);
    check(frameErr, "R8 stop sample low", frameErr, 1);
    pulse(holdRead);
    pulse(statusRead);

    // R2: noise spike shorter than half a bit
    holdLine(1'b1, 64);
    holdLine(1'b0, 12);
    holdLine(1'b1, 900);
    check(!dataReady, "R2 glitch rejected", dataReady, 0);
    // R2: a real start right after still works
    sendChar(8'hC3, 0, 1'b1);
    check(rxData == 8'hC3 && dataReady, "R2 start after glitch", rxData, 8'hC3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule